// File: doc/BRIEF.md
# Ping-Pong One-Shot DMA Channel Bank

This block moves data between seven peripheral word streams and a memory. The channels are numbered 0 to 6 and serve the SCSI port, network receive, network transmit, floppy, serial A receive, serial B receive and serial A transmit, in that order. Each channel keeps two descriptor sets. A set holds a start address, a byte length and a command word. At any time one set is the active one. Software refills the other set while a transfer runs, so a channel can chain buffers without stopping.

A register port, written with a single-cycle strobe and read combinationally, gives access to every descriptor word and to one control register per channel. Toward memory, the block issues one word per request and holds the request until it is acknowledged. Toward the peripherals, it takes words on a ready/valid handshake for inbound channels and offers words on one for outbound channels. Only one beat is in flight at a time. When several channels want a beat, the lowest channel number wins.

Top module: `pingpong_dma_bank`

## Requirements
- R1: After reset every channel is idle, its active set is 0, every armed, done, error and interrupt bit reads 0, `irq` is 0 and `memReq` is low.
- R2: The descriptor word of channel c, set s, word w (0 address, 1 length, 2 command) sits at 0x1000 + 0x20*c + 0x10*s + 4*w. The control register of channel c sits at 0xC00 + 0x10*c. Address and length read back what was written. In the control register, bit 0 is the active set, bit 1 running, bit 2 interrupt flag, bit 3 error, bits 4 and 5 the armed state of sets 0 and 1, and bit 8 the interrupt enable.
- R3: In a command word, bit 0 arms the set, bit 1 selects memory-to-peripheral (1) or peripheral-to-memory (0), and bit 2 is a read-only done flag. Any accepted command write clears done. Arming a set whose length is 0 leaves it unarmed.
- R4: An idle channel starts its active set when that set is armed. Otherwise, if the other set is armed, the channel makes that set active and starts it.
- R5: A peripheral-to-memory beat takes one word (`pInReady` high while `pInValid` is high) and writes it to memory at the set's address. The address then grows by 4 and the length shrinks by 4.
- R6: A memory-to-peripheral beat reads memory at the set's address. It offers the word on `pOutData` with that channel's `pOutValid` bit, holding both until ready, and then advances address and length.
- R7: A beat that starts with length 4 or less is the last. It leaves length 0, sets the set's done bit, disarms the set and sets the channel's interrupt flag. The flag drives `irq` when the enable bit is 1, and writing 1 to bit 2 clears it.
- R8: On completion, if the other set is armed, it becomes active and the channel keeps running. Otherwise the channel goes idle and the active set does not change.
- R9: Any descriptor write to the set a running channel is using is dropped. It sets the sticky error bit 3, which is cleared by writing 1 to it.
- R10: Writing 1 to control bit 16 toggles the active set of an idle channel. The write has no effect on a running channel.
- R11: When several channels can move a beat, the lowest channel number is served first, and at most one bit of `pInReady` or `pOutValid` is high at a time.
- R12: Only one memory request is outstanding at a time. `memReq`, `memAddr` and `memWrite` are held until `memAck`, and no word is offered to a peripheral while `memReq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 13 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| memReq | output | 1 | Memory beat request |
| memWrite | output | 1 | 1 for a memory write, 0 for a read |
| memAddr | output | AW | Memory byte address |
| memWData | output | DW | Memory write data |
| memAck | input | 1 | Memory beat accepted or read data valid |
| memRData | input | DW | Memory read data |
| pInData | input | NCH*DW | Inbound words, channel c in slice c |
| pInValid | input | NCH | Inbound word available per channel |
| pInReady | output | NCH | Inbound word taken per channel |
| pOutData | output | DW | Outbound word |
| pOutValid | output | NCH | Outbound word offered per channel |
| pOutReady | input | NCH | Outbound word accepted per channel |
| irq | output | NCH | Interrupt request per channel |

## Verification
Inbound transfers run against an always-valid source and against sources held back and then released. The first case shows that the length countdown and address step are right. The second shows that a channel blocked by its peripheral stays running and locks out writes to its live set. Outbound transfers face a randomly toggling ready, which shows that the word and the valid bit are held across stalls. Lengths that are not a multiple of four tell the rounding of the last beat from an exact countdown. Directed cases set two channels loose in the same cycle to show the priority. They also arm both sets of one channel to show the automatic switch, arm only the idle set to show the start-time flip, and arm a zero length.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

  // width of a channel index; the bank holds at most 2**CH_W channels
  localparam int unsigned CH_W = 3;
  // byte address width of the register port (map reaches 0x10FF)
  localparam int unsigned REG_AW = 13;

  typedef enum logic [1:0] {
    BEAT_IDLE,
    BEAT_MEM,
    BEAT_OUT
  } beatState_t;

  // strobes and selects handed from control to datapath
  typedef struct packed {
    logic [CH_W-1:0] selCh;    // descriptor addressed by the register port
    logic            selSet;
    logic            selLen;   // 1: length word, 0: address word
    logic            wrAddr;
    logic            wrLen;
    logic [CH_W-1:0] beatCh;   // descriptor the current beat uses
    logic            beatSet;
    logic            capIn;    // capture inbound peripheral word
    logic            capMem;   // capture memory read data
    logic            step;     // advance address and length of the beat set
  } dpStrobe_t;

endpackage

// File: rtl/dmab_prio.sv
module dmab_prio
  import dmab_pkg::*;
#(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0]    reqV,
  output logic            gntValid,
  output logic [CH_W-1:0] gntIdx
);

  // scan from the top so the lowest requesting index is left standing
  always_comb begin
    gntValid = |reqV;
    gntIdx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (reqV[i]) gntIdx = CH_W'(i);
    end
  end

endmodule

// File: rtl/dmab_dp.sv
module dmab_dp
  import dmab_pkg::*;
#(
  parameter int unsigned NCH = 7,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned LW  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          st,
  input  logic [31:0]        regWrData,
  input  logic [NCH*DW-1:0]  pInData,
  input  logic [DW-1:0]      memRData,
  output logic [31:0]        selWord,
  output logic               selLenZero,
  output logic               beatLast,
  output logic [AW-1:0]      beatAddr,
  output logic [DW-1:0]      beatData
);

  localparam int unsigned   BPW      = DW / 8;
  localparam logic [LW-1:0] STEP_LEN = LW'(BPW);
  localparam logic [AW-1:0] STEP_ADR = AW'(BPW);

  logic [AW-1:0] adrQ [NCH][2];
  logic [LW-1:0] lenQ [NCH][2];
  logic [LW-1:0] beatLen;

  assign beatAddr   = adrQ[st.beatCh][st.beatSet];
  assign beatLen    = lenQ[st.beatCh][st.beatSet];
  assign beatLast   = (beatLen <= STEP_LEN);
  assign selLenZero = (lenQ[st.selCh][st.selSet] == '0);

  always_comb begin
    selWord = '0;
    if (st.selLen) selWord[LW-1:0] = lenQ[st.selCh][st.selSet];
    else           selWord[AW-1:0] = adrQ[st.selCh][st.selSet];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin
        for (int s = 0; s < 2; s++) begin
          adrQ[c][s] <= '0;
          lenQ[c][s] <= '0;
        end
      end
      beatData <= '0;
    end else begin
      // control never writes the set a beat is stepping
      if (st.wrAddr) adrQ[st.selCh][st.selSet] <= regWrData[AW-1:0];
      if (st.wrLen)  lenQ[st.selCh][st.selSet] <= regWrData[LW-1:0];
      if (st.step) begin
        adrQ[st.beatCh][st.beatSet] <= beatAddr + STEP_ADR;
        lenQ[st.beatCh][st.beatSet] <= beatLast ? '0 : beatLen - STEP_LEN;
      end
      if (st.capIn)  beatData <= pInData[32'(st.beatCh)*DW +: DW];
      if (st.capMem) beatData <= memRData;
    end
  end

endmodule

// File: rtl/dmab_ctl.sv
module dmab_ctl
  import dmab_pkg::*;
#(
  parameter int unsigned NCH = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic [31:0]       selWord,
  input  logic              selLenZero,
  input  logic              beatLast,
  input  logic [NCH-1:0]    pInValid,
  input  logic [NCH-1:0]    pOutReady,
  input  logic              memAck,
  output dpStrobe_t         st,
  output logic [31:0]       regRdData,
  output logic              memReq,
  output logic              memWrite,
  output logic [NCH-1:0]    pInReady,
  output logic [NCH-1:0]    pOutValid,
  output logic [NCH-1:0]    irq
);

  // register decode
  logic [CH_W-1:0] descCh, ctlCh;
  logic            descSet;
  logic [1:0]      descWord;
  logic            isDesc, isCtl;

  assign descCh   = regAddr[7:5];
  assign descSet  = regAddr[4];
  assign descWord = regAddr[3:2];
  assign ctlCh    = regAddr[6:4];
  assign isDesc   = regAddr[12] && (regAddr[11:8] == '0) && (regAddr[1:0] == '0)
                    && (descWord != 2'd3) && (32'(descCh) < NCH);
  assign isCtl    = (regAddr[12:10] == 3'b011) && (regAddr[9:7] == '0)
                    && (regAddr[3:0] == '0) && (32'(ctlCh) < NCH);

  // per-channel state
  logic [NCH-1:0] actQ, runQ, errQ, irqQ, ienQ;
  logic [1:0]     armQ  [NCH];
  logic [1:0]     dirQ  [NCH];
  logic [1:0]     doneQ [NCH];

  beatState_t      stateQ;
  logic [CH_W-1:0] curCh;
  logic            curSet, curDir;

  logic descLocked, descWr, cmdWr, dropWr, ctlWr, finishNow;

  assign descLocked = isDesc && runQ[descCh] && (actQ[descCh] == descSet);
  assign descWr     = regWe && isDesc;
  assign cmdWr      = descWr && !descLocked && (descWord == 2'd2);
  assign dropWr     = descWr && descLocked;
  assign ctlWr      = regWe && isCtl;

  // arbitration over channels that can move a beat now
  logic [NCH-1:0]  eligV;
  logic            gntValid, gntDir;
  logic [CH_W-1:0] gntCh;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      eligV[c] = (stateQ == BEAT_IDLE) && runQ[c] && (dirQ[c][actQ[c]] || pInValid[c]);
    end
  end

  dmab_prio #(.N(NCH)) i_prio (
    .reqV     (eligV),
    .gntValid (gntValid),
    .gntIdx   (gntCh)
  );

  assign gntDir = dirQ[gntCh][actQ[gntCh]];

  always_comb begin
    st          = '0;
    st.selCh    = descCh;
    st.selSet   = descSet;
    st.selLen   = descWord[0];
    st.wrAddr   = descWr && !descLocked && (descWord == 2'd0);
    st.wrLen    = descWr && !descLocked && (descWord == 2'd1);
    st.beatCh   = (stateQ == BEAT_IDLE) ? gntCh : curCh;
    st.beatSet  = (stateQ == BEAT_IDLE) ? actQ[gntCh] : curSet;
    st.capIn    = gntValid && !gntDir;
    st.capMem   = (stateQ == BEAT_MEM) && memAck && curDir;
    st.step     = ((stateQ == BEAT_MEM) && memAck && !curDir)
                  || ((stateQ == BEAT_OUT) && pOutReady[curCh]);
  end

  assign finishNow = st.step && beatLast;

  assign memReq    = (stateQ == BEAT_MEM);
  assign memWrite  = memReq && !curDir;
  assign pInReady  = st.capIn ? (NCH'(1) << gntCh) : '0;
  assign pOutValid = (stateQ == BEAT_OUT) ? (NCH'(1) << curCh) : '0;
  assign irq       = irqQ & ienQ;

  // beat sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= BEAT_IDLE;
      curCh  <= '0;
      curSet <= 1'b0;
      curDir <= 1'b0;
    end else begin
      unique case (stateQ)
        BEAT_IDLE: if (gntValid) begin
          curCh  <= gntCh;
          curSet <= actQ[gntCh];
          curDir <= gntDir;
          stateQ <= BEAT_MEM;
        end
        BEAT_MEM:  if (memAck) stateQ <= curDir ? BEAT_OUT : BEAT_IDLE;
        BEAT_OUT:  if (pOutReady[curCh]) stateQ <= BEAT_IDLE;
        default:   stateQ <= BEAT_IDLE;
      endcase
    end
  end

  // channel bookkeeping: arming, flips, completion, flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actQ <= '0;
      runQ <= '0;
      errQ <= '0;
      irqQ <= '0;
      ienQ <= '0;
      for (int c = 0; c < NCH; c++) begin
        armQ[c]  <= '0;
        dirQ[c]  <= '0;
        doneQ[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (cmdWr && descCh == CH_W'(c)) begin
          armQ[c][descSet]  <= regWrData[0] && !selLenZero;
          dirQ[c][descSet]  <= regWrData[1];
          doneQ[c][descSet] <= 1'b0;
        end
        if (ctlWr && ctlCh == CH_W'(c)) begin
          ienQ[c] <= regWrData[8];
          if (regWrData[2]) irqQ[c] <= 1'b0;
          if (regWrData[3]) errQ[c] <= 1'b0;
          if (regWrData[16] && !runQ[c]) actQ[c] <= ~actQ[c];
        end
        if (dropWr && descCh == CH_W'(c)) errQ[c] <= 1'b1;

        if (finishNow && curCh == CH_W'(c)) begin
          doneQ[c][curSet] <= 1'b1;
          armQ[c][curSet]  <= 1'b0;
          irqQ[c]          <= 1'b1;
          if (armQ[c][~curSet]) actQ[c] <= ~curSet;
          else                  runQ[c] <= 1'b0;
        end else if (!runQ[c] && !(ctlWr && ctlCh == CH_W'(c))) begin
          if (armQ[c][actQ[c]]) begin
            runQ[c] <= 1'b1;
          end else if (armQ[c][~actQ[c]]) begin
            runQ[c] <= 1'b1;
            actQ[c] <= ~actQ[c];
          end
        end
      end
    end
  end

  // read mux
  always_comb begin
    regRdData = '0;
    if (isCtl) begin
      regRdData[0] = actQ[ctlCh];
      regRdData[1] = runQ[ctlCh];
      regRdData[2] = irqQ[ctlCh];
      regRdData[3] = errQ[ctlCh];
      regRdData[5:4] = armQ[ctlCh];
      regRdData[8] = ienQ[ctlCh];
    end else if (isDesc) begin
      if (descWord == 2'd2) begin
        regRdData[0] = armQ[descCh][descSet];
        regRdData[1] = dirQ[descCh][descSet];
        regRdData[2] = doneQ[descCh][descSet];
      end else begin
        regRdData = selWord;
      end
    end
  end

endmodule

// File: rtl/pingpong_dma_bank.sv
module pingpong_dma_bank
  import dmab_pkg::*;
#(
  parameter int unsigned NCH = 7,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned LW  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memReq,
  output logic              memWrite,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memWData,
  input  logic              memAck,
  input  logic [DW-1:0]     memRData,
  input  logic [NCH*DW-1:0] pInData,
  input  logic [NCH-1:0]    pInValid,
  output logic [NCH-1:0]    pInReady,
  output logic [DW-1:0]     pOutData,
  output logic [NCH-1:0]    pOutValid,
  input  logic [NCH-1:0]    pOutReady,
  output logic [NCH-1:0]    irq
);

  dpStrobe_t      st;
  logic [31:0]    selWord;
  logic           selLenZero, beatLast;
  logic [AW-1:0]  beatAddr;
  logic [DW-1:0]  beatData;

  dmab_ctl #(.NCH(NCH)) i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .selWord    (selWord),
    .selLenZero (selLenZero),
    .beatLast   (beatLast),
    .pInValid   (pInValid),
    .pOutReady  (pOutReady),
    .memAck     (memAck),
    .st         (st),
    .regRdData  (regRdData),
    .memReq     (memReq),
    .memWrite   (memWrite),
    .pInReady   (pInReady),
    .pOutValid  (pOutValid),
    .irq        (irq)
  );

  dmab_dp #(.NCH(NCH), .AW(AW), .DW(DW), .LW(LW)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .regWrData  (regWrData),
    .pInData    (pInData),
    .memRData   (memRData),
    .selWord    (selWord),
    .selLenZero (selLenZero),
    .beatLast   (beatLast),
    .beatAddr   (beatAddr),
    .beatData   (beatData)
  );

  assign memAddr  = beatAddr;
  assign memWData = beatData;
  assign pOutData = beatData;

endmodule

// File: rtl/dmab_chk.sv
module dmab_chk #(
  parameter int unsigned NCH = 7,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic           memReq,
  input logic           memWrite,
  input logic [AW-1:0]  memAddr,
  input logic           memAck,
  input logic [NCH-1:0] pInValid,
  input logic [NCH-1:0] pInReady,
  input logic [DW-1:0]  pOutData,
  input logic [NCH-1:0] pOutValid,
  input logic [NCH-1:0] pOutReady
);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite)));

  // R12
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && (|pOutValid)));

  // R11
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pInReady) && $onehot0(pOutValid) && !((|pInReady) && (|pOutValid)));

  // R5
  take_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pInReady & ~pInValid) == '0);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(pOutValid & ~pOutReady)) |=> ($stable(pOutValid) && $stable(pOutData)));

endmodule

bind pingpong_dma_bank dmab_chk #(.NCH(NCH), .AW(AW), .DW(DW)) i_dmab_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memWrite  (memWrite),
  .memAddr   (memAddr),
  .memAck    (memAck),
  .pInValid  (pInValid),
  .pInReady  (pInReady),
  .pOutData  (pOutData),
  .pOutValid (pOutValid),
  .pOutReady (pOutReady)
);

// File: tb/test_pingpong_dma_bank.sv
`timescale 1ns/1ps
module test_pingpong_dma_bank;

  localparam int NCH = 7;
  localparam int MW  = 1024;

  logic          clk = 1'b0;
  logic          rstN;
  logic          regWe;
  logic [12:0]   regAddr;
  logic [31:0]   regWrData, regRdData;
  logic          memReq, memWrite, memAck;
  logic [31:0]   memAddr, memWData, memRData;
  logic [NCH*32-1:0] pInData;
  logic [NCH-1:0] pInValid, pInReady, pOutValid, pOutReady, irq;
  logic [31:0]   pOutData;

  always #2.5 clk = ~clk;

  pingpong_dma_bank i_pingpong_dma_bank (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memWData(memWData),
    .memAck(memAck), .memRData(memRData), .pInData(pInData),
    .pInValid(pInValid), .pInReady(pInReady), .pOutData(pOutData),
    .pOutValid(pOutValid), .pOutReady(pOutReady), .irq(irq)
  );

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  function automatic logic [31:0] initPat(int i);
    return 32'hD00D_0000 | 32'(i);
  endfunction

  function automatic logic [12:0] dAddr(int c, int s, int w);
    return 13'(32'h1000 + c * 32 + s * 16 + w * 4);
  endfunction

  function automatic logic [12:0] cAddr(int c);
    return 13'(32'hC00 + c * 16);
  endfunction

  function automatic logic [31:0] inWord(int c, logic [15:0] n);
    return {8'(c), 8'h5A, n};
  endfunction

  // memory model with random acknowledge delay
  logic [31:0] mem [MW];
  int unsigned dly;
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MW; i++) mem[i] <= initPat(i);
      memAck   <= 1'b0;
      memRData <= '0;
      dly      <= 0;
    end else if (memAck) begin
      memAck <= 1'b0;
    end else if (memReq) begin
      if (dly == 0) begin
        memAck <= 1'b1;
        if (memWrite) mem[memAddr[11:2]] <= memWData;
        else          memRData <= mem[memAddr[11:2]];
        dly <= $urandom % 3;
      end else begin
        dly <= dly - 1;
      end
    end
  end

  // inbound sources: per-channel counters of taken words
  logic [15:0] inCnt [NCH];
  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rstN) inCnt[c] <= '0;
      else if (pInReady[c] && pInValid[c]) inCnt[c] <= inCnt[c] + 16'd1;
    end
  end
  always_comb begin
    for (int c = 0; c < NCH; c++) pInData[c*32 +: 32] = inWord(c, inCnt[c]);
  end

  // outbound sinks with random ready
  logic [31:0] recv [NCH][64];
  logic [7:0]  rCnt [NCH];
  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rstN) rCnt[c] <= '0;
      else if (pOutValid[c] && pOutReady[c]) begin
        recv[c][rCnt[c][5:0]] <= pOutData;
        rCnt[c] <= rCnt[c] + 8'd1;
      end
    end
  end
  always @(negedge clk) pOutReady <= NCH'($urandom);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle(int c);
    logic [31:0] v;
    repeat (3) @(negedge clk);
    for (int n = 0; n < 3000; n++) begin
      rd(cAddr(c), v);
      if (!v[1]) break;
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    logic [31:0] v, v2;
    logic [15:0] startN;
    void'($urandom(32'd20240611));
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWrData = '0; pInValid = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rd(cAddr(0), v);       check("R1 ctl ch0", v, 32'h0);
    rd(cAddr(6), v);       check("R1 ctl ch6", v, 32'h0);
    rd(dAddr(6, 1, 2), v); check("R1 cmd ch6 set1", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 memReq", 32'(memReq), 32'h0);

    // R2: descriptor readback
    wr(dAddr(3, 1, 0), 32'h0000_0ABC);
    wr(dAddr(3, 1, 1), 32'h0000_1234);
    rd(dAddr(3, 1, 0), v); check("R2 addr readback", v, 32'h0000_0ABC);
    rd(dAddr(3, 1, 1), v); check("R2 len readback", v, 32'h0000_1234);
    rd(dAddr(3, 0, 0), v); check("R2 other set untouched", v, 32'h0);

    // R3: zero-length arm stays unarmed
    wr(dAddr(3, 0, 1), 32'h0);
    wr(dAddr(3, 0, 2), 32'h1);
    repeat (2) @(negedge clk);
    rd(dAddr(3, 0, 2), v); check("R3 zero length not armed", v, 32'h0);
    rd(cAddr(3), v);       check("R3 zero length not running", v & 32'h3, 32'h0);

    // R5 R7: inbound ch2, 4 beats at 0x100
    wr(cAddr(2), 32'h100);
    wr(dAddr(2, 0, 0), 32'h100);
    wr(dAddr(2, 0, 1), 32'd16);
    startN = inCnt[2];
    pInValid[2] = 1'b1;
    wr(dAddr(2, 0, 2), 32'h1);
    waitIdle(2);
    for (int k = 0; k < 4; k++)
      check("R5 inbound word", mem[(32'h100 >> 2) + k], inWord(2, startN + 16'(k)));
    rd(dAddr(2, 0, 0), v); check("R5 addr advanced", v, 32'h110);
    rd(dAddr(2, 0, 1), v); check("R7 len zero", v, 32'h0);
    rd(dAddr(2, 0, 2), v); check("R7 done and disarmed", v, 32'h4);
    check("R7 irq raised", 32'(irq[2]), 32'h1);
    wr(cAddr(2), 32'h104);
    check("R7 irq cleared", 32'(irq[2]), 32'h0);

    // R6: outbound ch6, 3 beats from 0x200
    wr(dAddr(6, 0, 0), 32'h200);
    wr(dAddr(6, 0, 1), 32'd12);
    startN = 16'(rCnt[6]);
    wr(dAddr(6, 0, 2), 32'h3);
    waitIdle(6);
    for (int k = 0; k < 3; k++)
      check("R6 outbound word", recv[6][(startN + 16'(k)) % 64], initPat((32'h200 >> 2) + k));

    // R9 R10: writes to a running channel's live set
    wr(dAddr(0, 0, 0), 32'h000);
    wr(dAddr(0, 0, 1), 32'd64);
    wr(dAddr(0, 0, 2), 32'h1);
    repeat (3) @(negedge clk);
    rd(cAddr(0), v); check("R9 channel running", v & 32'h3, 32'h2);
    wr(dAddr(0, 0, 0), 32'h777);
    rd(dAddr(0, 0, 0), v); check("R9 live addr write dropped", v, 32'h0);
    rd(cAddr(0), v); check("R9 error sticky", (v >> 3) & 1, 32'h1);
    wr(cAddr(0), 32'h1_0000);
    rd(cAddr(0), v); check("R10 flip ignored while running", v & 32'h1, 32'h0);
    wr(cAddr(0), 32'h8);
    rd(cAddr(0), v); check("R9 error cleared", (v >> 3) & 1, 32'h0);
    pInValid[0] = 1'b1;
    waitIdle(0);
    rd(dAddr(0, 0, 0), v); check("R9 transfer unaffected", v, 32'h040);
    pInValid[0] = 1'b0;

    // R8: both sets of ch4 armed, automatic switch
    wr(dAddr(4, 0, 0), 32'h300);
    wr(dAddr(4, 0, 1), 32'd8);
    wr(dAddr(4, 1, 0), 32'h340);
    wr(dAddr(4, 1, 1), 32'd8);
    startN = inCnt[4];
    wr(dAddr(4, 0, 2), 32'h1);
    wr(dAddr(4, 1, 2), 32'h1);
    pInValid[4] = 1'b1;
    waitIdle(4);
    rd(cAddr(4), v);       check("R8 switched to set1", v & 32'h3, 32'h1);
    rd(dAddr(4, 0, 2), v); rd(dAddr(4, 1, 2), v2);
    check("R8 both sets done", {v[2], v2[2]}, 32'h3);
    check("R8 set1 data", mem[(32'h340 >> 2) + 1], inWord(4, startN + 16'd3));

    // R4: only the inactive set armed, then R10 idle flip
    wr(dAddr(5, 1, 0), 32'h380);
    wr(dAddr(5, 1, 1), 32'd10);
    wr(dAddr(5, 1, 2), 32'h1);
    repeat (2) @(negedge clk);
    rd(cAddr(5), v); check("R4 start on other set", v & 32'h3, 32'h3);
    pInValid[5] = 1'b1;
    waitIdle(5);
    rd(dAddr(5, 1, 0), v); check("R7 partial last beat", v, 32'h38C);
    wr(cAddr(5), 32'h1_0000);
    rd(cAddr(5), v); check("R10 idle flip", v & 32'h3, 32'h0);

    // R11: ch0 and ch1 released in the same cycle
    rd(cAddr(0), v);
    wr(dAddr(0, v[0], 0), 32'h040);
    wr(dAddr(0, v[0], 1), 32'd8);
    rd(cAddr(1), v2);
    wr(dAddr(1, v2[0], 0), 32'h080);
    wr(dAddr(1, v2[0], 1), 32'd8);
    wr(dAddr(1, v2[0], 2), 32'h1);
    wr(dAddr(0, v[0], 2), 32'h1);
    repeat (3) @(negedge clk);
    pInValid[1:0] = 2'b11;
    for (int n = 0; n < 20 && !memReq; n++) @(negedge clk);
    check("R11 lowest channel first", memAddr, 32'h040);
    waitIdle(0);
    waitIdle(1);
    check("R11 ch1 served after", mem[(32'h080 >> 2) + 1][31:24], 32'h1);
    pInValid = '0;

    // random rounds on idle channels (R5 R6 R7)
    for (int r = 0; r < 24; r++) begin
      int c, nB, len, base;
      logic dir;
      c    = $urandom % NCH;
      dir  = 1'($urandom);
      nB   = 1 + ($urandom % 8);
      len  = nB * 4 - (($urandom % 2 == 1) ? int'($urandom % 4) : 0);
      base = 32'h400 + c * 32'h80;
      rd(cAddr(c), v);
      wr(dAddr(c, v[0], 0), 32'(base));
      wr(dAddr(c, v[0], 1), 32'(len));
      startN = dir ? 16'(rCnt[c]) : inCnt[c];
      pInValid[c] = ~dir;
      wr(dAddr(c, v[0], 2), {30'h0, dir, 1'b1});
      waitIdle(c);
      for (int k = 0; k < nB; k++) begin
        if (dir)
          check("R6 random outbound", recv[c][(startN + 16'(k)) % 64], mem[(base >> 2) + k]);
        else
          check("R5 random inbound", mem[(base >> 2) + k], inWord(c, startN + 16'(k)));
      end
      rd(dAddr(c, v[0], 0), v2); check("R5 random addr step", v2, 32'(base + nB * 4));
      rd(dAddr(c, v[0], 1), v2); check("R7 random len zero", v2, 32'h0);
      pInValid[c] = 1'b0;
    end

    finish();
  end

endmodule